// File: doc/BRIEF.md
# External Interrupt Aggregator

This block collects a set of external interrupt inputs, organised in banks of 32, and folds them into one interrupt line for the platform interrupt controller. Every input is brought into the block clock domain through two flops. It is then judged against a programmable trigger type: high level, low level, rising edge or falling edge. An edge sets a sticky pending bit that stays set until software clears it. A level input reports its live qualified value instead.

Software sees everything through a word-wide APB-style slave port. Per bank, it can program the 2-bit trigger fields, write a mask vector and write a clear vector, and it can read the pending status. The output line is registered. It is high whenever at least one unmasked source is pending. Software clears an edge by writing its clear bit to 1 and then back to 0. The same pulse is the clean way to retire any old event after a trigger type has been rewritten.

Top module: `ext_irq_aggregator`

## Requirements
- R1: After reset, irq_o is 0, every mask bit reads 1, and every trigger field, clear bit and status bit reads 0.
- R2: Source n lives in bank n/32 at bit n%32, and bank b starts at byte offset 32*b. Within a bank, the offsets are: 0x04 and 0x08 hold trigger fields, 0x10 is clear (read/write), 0x14 is mask (read/write) and 0x1C is status (read-only). Bit p uses the word at 0x04+4*(p/16), at bit position 2*(p%16).
- R3: Trigger code 0 (high level) reports status 1 while the synchronised input is 1. Code 1 (low level) reports status 1 while it is 0. Both follow the input live.
- R4: Code 2 (rising) and code 3 (falling) set a sticky status bit on the matching transition of the synchronised input. The bit stays set until it is cleared, and the opposite transition does not set it.
- R5: While a source's clear bit is 1, its status reads 0 and edges arriving in that time are lost. Once the bit returns to 0, new events are seen again.
- R6: If a level source whose input is active is switched to an edge type and given a clear pulse, it reads 0 until a real new edge arrives.
- R7: A mask bit of 1 keeps its source off irq_o but leaves its status visible. A mask bit of 0 lets the source drive irq_o.
- R8: irq_o is a register. On each clock it takes the OR of (status AND NOT mask) as it stood before that edge.
- R9: Reads at unimplemented offsets (other words, banks at or above the bank count, addresses not word aligned) return 0. Writes to those offsets, and writes to status, change nothing.
- R10: An input change reaches level status two clocks after it is sampled and irq_o three clocks after, because of the two-flop synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | External interrupt inputs, source n on bit n |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 16 | Byte address within the 64 KiB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, 0 when not selected |
| irq_o | output | 1 | Aggregated interrupt toward the platform controller |

## Verification
The bench aims at the point where a level source is switched to an edge type while its input is active. A design with stale edge history would show a spurious pending bit there. It checks that a clear bit held high blocks edges, which a design that latched on the release cycle would miss, and that an edge stays pending after the input drops, which a design treating edges like levels would lose. It counts the synchroniser latency exactly and probes aliasing through out-of-range bank addresses and reserved words, where sloppy decode would overwrite bank 0.

// File: rtl/ext_irq_aggregator.sv
module ext_irq_aggregator #(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_BANKS*32-1:0] src_i,
  input  logic                    psel,
  input  logic                    penable,
  input  logic                    pwrite,
  input  logic [ADDR_W-1:0]       paddr,
  input  logic [31:0]             pwdata,
  output logic [31:0]             prdata,
  output logic                    irq_o
);
  localparam int BW    = 32;
  localparam int N     = NUM_BANKS * BW;
  localparam int SEL_W = ADDR_W - 5;

  logic [N-1:0]     sync1_q, sync2_q, prev_q, edge_q;
  logic [N-1:0]     mask_q, clr_q, lvl, hit, is_edge, stat;
  logic [2*N-1:0]   trig_q;
  logic [SEL_W-1:0] bank_sel;
  logic [2:0]       reg_idx;
  logic             aligned, wr_en;
  logic [31:0]      rd_word;

  assign bank_sel = paddr[ADDR_W-1:5];
  assign reg_idx  = paddr[4:2];
  assign aligned  = (paddr[1:0] == 2'b00);
  assign wr_en    = psel & penable & pwrite & aligned;

  for (genvar n = 0; n < N; n++) begin : g_src
    logic [1:0] t;
    assign t          = trig_q[2*n +: 2];
    assign is_edge[n] = t[1];
    assign lvl[n]     = (t == 2'd0) ? sync2_q[n] : (t == 2'd1) ? ~sync2_q[n] : 1'b0;
    assign hit[n]     = (t == 2'd2) ? (sync2_q[n] & ~prev_q[n]) :
                        (t == 2'd3) ? (~sync2_q[n] & prev_q[n]) : 1'b0;
    assign stat[n]    = t[1] ? edge_q[n] : (lvl[n] & ~clr_q[n]);

    p_clear_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_q[n] && $past(clr_q[n]) |-> !stat[n]);

    p_edge_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      is_edge[n] && $past(is_edge[n]) && $past(stat[n]) && !$past(clr_q[n]) |-> stat[n]);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic          bank_wr;
    logic [BW-1:0] m_q, c_q;
    logic [2*BW-1:0] t_q;

    assign bank_wr = wr_en && (bank_sel == SEL_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m_q <= '1;
        c_q <= '0;
        t_q <= '0;
      end else if (bank_wr) begin
        case (reg_idx)
          3'd1:    t_q[BW-1:0]    <= pwdata;
          3'd2:    t_q[2*BW-1:BW] <= pwdata;
          3'd4:    c_q            <= pwdata;
          3'd5:    m_q            <= pwdata;
          default: ;
        endcase
      end
    end

    assign mask_q[b*BW +: BW]   = m_q;
    assign clr_q[b*BW +: BW]    = c_q;
    assign trig_q[b*2*BW +: 2*BW] = t_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      edge_q  <= '0;
      irq_o   <= 1'b0;
    end else begin
      sync1_q <= src_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      edge_q  <= (edge_q | hit) & ~clr_q & is_edge;
      irq_o   <= |(stat & ~mask_q);
    end
  end

  always_comb begin
    rd_word = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (aligned && bank_sel == SEL_W'(b)) begin
        case (reg_idx)
          3'd1:    rd_word = trig_q[b*2*BW +: BW];
          3'd2:    rd_word = trig_q[b*2*BW+BW +: BW];
          3'd4:    rd_word = clr_q[b*BW +: BW];
          3'd5:    rd_word = mask_q[b*BW +: BW];
          3'd7:    rd_word = stat[b*BW +: BW];
          default: rd_word = '0;
        endcase
      end
    end
  end

  assign prdata = psel ? rd_word : '0;

  p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (&$past(mask_q)) |-> !irq_o);

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    psel && (bank_sel >= SEL_W'(NUM_BANKS) || reg_idx == 3'd0 || reg_idx == 3'd3 ||
             reg_idx == 3'd6 || !aligned) |-> prdata == 32'd0);
endmodule

// File: tb/test_ext_irq_aggregator.sv
`timescale 1ns/1ps
module test_ext_irq_aggregator;
  localparam int NB = 2;
  localparam int NS = NB * 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [15:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq;
  bit          done = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  ext_irq_aggregator i_ext_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .src_i(src), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_o(irq)
  );

  int m_type[NS];
  bit m_mask[NS], m_clr[NS], ms1[NS], ms2[NS], mpv[NS], mep[NS];
  bit m_irq;

  function automatic bit m_stat(int n);
    if (m_type[n] >= 2) return mep[n];
    if (m_clr[n]) return 1'b0;
    return (m_type[n] == 0) ? ms2[n] : !ms2[n];
  endfunction

  function automatic logic [31:0] m_read(int a);
    logic [31:0] r = '0;
    int b = a / 32;
    int idx = (a / 4) % 8;
    if (b >= NB || (a % 4) != 0) return '0;
    for (int k = 0; k < 32; k++) begin
      case (idx)
        1, 2: if (k < 16) r[2*k +: 2] = 2'(m_type[b*32 + (idx-1)*16 + k]);
        4: r[k] = m_clr[b*32+k];
        5: r[k] = m_mask[b*32+k];
        7: r[k] = m_stat(b*32+k);
        default: ;
      endcase
    end
    return r;
  endfunction

  function automatic void m_write(int a, logic [31:0] d);
    int b = a / 32;
    int idx = (a / 4) % 8;
    if (b >= NB || (a % 4) != 0) return;
    for (int k = 0; k < 32; k++) begin
      case (idx)
        1, 2: if (k < 16) m_type[b*32 + (idx-1)*16 + k] = int'(d[2*k +: 2]);
        4: m_clr[b*32+k] = d[k];
        5: m_mask[b*32+k] = d[k];
        default: ;
      endcase
    end
  endfunction

  always @(posedge clk) begin
    bit any;
    bit h;
    if (!rst_n) begin
      for (int n = 0; n < NS; n++) begin
        m_type[n] = 0; m_mask[n] = 1; m_clr[n] = 0;
        ms1[n] = 0; ms2[n] = 0; mpv[n] = 0; mep[n] = 0;
      end
      m_irq = 0;
    end else begin
      any = 0;
      for (int n = 0; n < NS; n++) if (m_stat(n) && !m_mask[n]) any = 1;
      for (int n = 0; n < NS; n++) begin
        h = (m_type[n] == 2 && ms2[n] && !mpv[n]) || (m_type[n] == 3 && !ms2[n] && mpv[n]);
        if (m_clr[n] || m_type[n] < 2) mep[n] = 0;
        else if (h) mep[n] = 1;
        mpv[n] = ms2[n]; ms2[n] = ms1[n]; ms1[n] = src[n];
      end
      m_irq = any;
      if (psel && penable && pwrite) m_write(int'(paddr), pwdata);
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) chk("R8 irq vs model", {31'd0, irq}, {31'd0, m_irq});

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic apb_wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd_exp(string tag, logic [15:0] a, logic [31:0] exp);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk); penable = 1;
    chk(tag, prdata, exp);
    chk({tag, " model"}, prdata, m_read(int'(a)));
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic rd_chk(string tag, logic [15:0] a);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk); penable = 1;
    chk(tag, prdata, m_read(int'(a)));
    @(negedge clk); psel = 0; penable = 0;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL R8 watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait_clk(3);
    rst_n = 1;
    wait_clk(1);
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    rd_exp("R1 mask bank0", 16'h0014, 32'hFFFF_FFFF);
    rd_exp("R1 mask bank1", 16'h0034, 32'hFFFF_FFFF);
    rd_exp("R1 type word", 16'h0004, 32'd0);
    rd_exp("R1 type word", 16'h0028, 32'd0);
    rd_exp("R1 clear", 16'h0010, 32'd0);
    rd_exp("R1 status", 16'h001C, 32'd0);

    apb_wr(16'h0014, ~(32'd1 << 5));
    wait_clk(1);
    src[5] = 1;
    wait_clk(2);
    chk("R10 irq still low after 2 clocks", {31'd0, irq}, 32'd0);
    wait_clk(1);
    chk("R10 irq high after 3 clocks", {31'd0, irq}, 32'd1);
    rd_exp("R3 level high status", 16'h001C, 32'h20);
    apb_wr(16'h0004, 32'd1 << 10);
    rd_exp("R3 level low, input high", 16'h001C, 32'h0);
    src[5] = 0;
    wait_clk(3);
    rd_exp("R3 level low, input low", 16'h001C, 32'h20);
    apb_wr(16'h0014, 32'hFFFF_FFFF);
    wait_clk(2);
    chk("R7 masked source off irq", {31'd0, irq}, 32'd0);
    rd_exp("R7 masked status visible", 16'h001C, 32'h20);

    apb_wr(16'h0024, 32'd2 << 16);
    apb_wr(16'h0028, 32'd3 << 18);
    @(negedge clk); src[40] = 1;
    @(negedge clk); src[40] = 0;
    wait_clk(4);
    rd_exp("R4 rising pending", 16'h003C, 32'h100);
    wait_clk(5);
    rd_exp("R4 rising sticky", 16'h003C, 32'h100);
    src[57] = 1;
    wait_clk(4);
    rd_exp("R4 falling ignores rise", 16'h003C, 32'h100);
    src[57] = 0;
    wait_clk(4);
    rd_exp("R4 falling pending", 16'h003C, 32'h0200_0100);
    chk("R7 bank1 masked", {31'd0, irq}, 32'd0);
    apb_wr(16'h0034, ~(32'd1 << 8));
    wait_clk(1);
    chk("R8 irq after unmask", {31'd0, irq}, 32'd1);

    apb_wr(16'h0030, 32'd1 << 8);
    wait_clk(1);
    rd_exp("R5 cleared", 16'h003C, 32'h0200_0000);
    @(negedge clk); src[40] = 1;
    @(negedge clk); src[40] = 0;
    wait_clk(4);
    rd_exp("R5 edge lost under clear", 16'h003C, 32'h0200_0000);
    chk("R8 irq low after clear", {31'd0, irq}, 32'd0);
    apb_wr(16'h0030, 32'd0);
    wait_clk(4);
    rd_exp("R5 released, no event", 16'h003C, 32'h0200_0000);
    @(negedge clk); src[40] = 1;
    @(negedge clk); src[40] = 0;
    wait_clk(4);
    rd_exp("R5 new edge after release", 16'h003C, 32'h0200_0100);
    apb_wr(16'h0010, 32'd1 << 5);
    rd_exp("R5 level held by clear", 16'h001C, 32'h0);
    apb_wr(16'h0010, 32'd0);
    rd_exp("R5 level back after clear", 16'h001C, 32'h20);

    src[3] = 1;
    wait_clk(3);
    rd_exp("R3 second level source", 16'h001C, 32'h28);
    apb_wr(16'h0004, (32'd1 << 10) | (32'd2 << 6));
    apb_wr(16'h0010, 32'd1 << 3);
    apb_wr(16'h0010, 32'd0);
    wait_clk(3);
    rd_exp("R6 no spurious edge", 16'h001C, 32'h20);
    src[3] = 0;
    wait_clk(3);
    src[3] = 1;
    wait_clk(4);
    rd_exp("R6 real edge after type change", 16'h001C, 32'h28);

    rd_exp("R2 type word bank0", 16'h0004, (32'd1 << 10) | (32'd2 << 6));
    rd_exp("R2 upper type word bank0", 16'h0008, 32'd0);
    rd_exp("R2 type word bank1 low", 16'h0024, 32'd2 << 16);
    rd_exp("R2 type word bank1 high", 16'h0028, 32'd3 << 18);

    apb_wr(16'h000C, 32'hFFFF_FFFF);
    apb_wr(16'h0018, 32'hFFFF_FFFF);
    apb_wr(16'h001C, 32'h0);
    apb_wr(16'h0054, 32'h0);
    apb_wr(16'h0044, 32'hFFFF_FFFF);
    apb_wr(16'h1004, 32'hFFFF_FFFF);
    apb_wr(16'h0015, 32'h0);
    rd_exp("R9 reserved word", 16'h000C, 32'd0);
    rd_exp("R9 reserved word", 16'h0018, 32'd0);
    rd_exp("R9 bank beyond range", 16'h0054, 32'd0);
    rd_exp("R9 bank beyond range", 16'h0044, 32'd0);
    rd_exp("R9 far offset", 16'h1004, 32'd0);
    rd_exp("R9 unaligned", 16'h0015, 32'd0);
    rd_exp("R9 mask bank0 untouched", 16'h0014, 32'hFFFF_FFFF);
    rd_exp("R9 type bank0 untouched", 16'h0004, (32'd1 << 10) | (32'd2 << 6));
    rd_exp("R9 status unchanged by write", 16'h001C, 32'h28);

    apb_wr(16'h0004, 32'h1B1B_E4E4);
    apb_wr(16'h0008, 32'h4E4E_B1B1);
    apb_wr(16'h0024, 32'hD8D8_2727);
    apb_wr(16'h0028, 32'h7272_8D8D);
    apb_wr(16'h0014, 32'h0F0F_0F0F);
    apb_wr(16'h0034, 32'hF0F0_F0F0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); src = {$urandom, $urandom};
      rd_chk("R3 mixed traffic bank0", 16'h001C);
      rd_chk("R4 mixed traffic bank1", 16'h003C);
      if (i % 8 == 7) begin
        apb_wr(16'h0030, 32'h5555_AAAA);
        apb_wr(16'h0030, 32'h0);
      end
    end

    wait_clk(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule